// File: doc/BRIEF.md
# SPI Master with Software Chip Select

A single-slave SPI master placed behind a small 32-bit register bus. Software sets the clock mode, word width and serial clock divider in a configuration register, raises chip select through a control bit, and then starts each word by writing it to the transmit data register. The block shifts the word out on MOSI, MSB first, and captures MISO in the same exchange. At the end of the word it sets a completion flag. Software clears that flag by writing zero to it before it starts the next word.

The serial clock comes from a separate prescale engine. That engine divides the system clock by a programmable half-period. Chip select is never sequenced by hardware. It follows the control bit alone, so software can hold the slave selected across any number of words.

Top module: `spi_reg_master`

## Requirements
- R1: After reset, chip select (`spi_cs_n`) is high. The configuration, completion and busy registers all read 0, and `spi_sclk` and `spi_mosi` are low.
- R2: Bit 0 of the control register (offset 0x00) drives chip select. Writing 1 drives `spi_cs_n` low and writing 0 drives it high, starting with the cycle after the write.
- R3: The configuration register (offset 0x04) reads back all 32 bits exactly as they were written.
- R4: While no word is shifting, `spi_sclk` rests at configuration bit 11 (polarity). A word produces 2N clock toggles and then returns the clock to that level. N is 8 when configuration bit 5 is clear and 16 when it is set.
- R5: Configuration bit 12 selects the phase. When it is 0, MISO is sampled on odd toggles (leading edges) and MOSI changes on even toggles. When it is 1, MOSI changes on leading edges after the first one and MISO is sampled on trailing edges. MOSI changes at no other time during a word.
- R6: Data leaves MSB first. In 8-bit mode only bits 7:0 of the written word are sent. MOSI is low whenever no word is shifting.
- R7: In 16-bit mode all 16 bits are exchanged. The data-in register (offset 0x0C) returns the received word in bits 15:0, with the low byte in bits 7:0, and zeros above.
- R8: A word started at clock edge E sets the completion register (offset 0x10, bit 0) at edge E + 2·N·D. Writing 0 to that register clears it. A nonzero write leaves it unchanged. A completion in the same cycle as a clear wins.
- R9: A write to data-out (offset 0x08) while a word is shifting is ignored, and the word in progress continues unchanged.
- R10: Bit 0 of the status register (offset 0x14) reads 1 from the edge that starts a word up to the edge that completes it.
- R11: Configuration bits 4:0 hold a divider field F. Each half-period of the serial clock lasts D = F + 1 system clocks, and the first edge of a word comes D cycles after the start.
- R12: In 8-bit mode the data-in register returns the received byte zero-extended to 32 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to slave |
| spi_miso | input | 1 | Serial data from slave |
| spi_cs_n | output | 1 | Active-low slave select |

## Verification
Register writes and chip select take effect one edge after the write is accepted. Each serial clock edge falls D cycles after the previous one, and busy and completion change together at edge 2·N·D after the start. The bench reference model counts system cycles since the start and derives the expected SCLK level, MOSI bit and slave MISO bit from that count. It compares the pins at every falling edge, where all registered outputs have settled. For the timed words, the bench reads status and completion one cycle before and exactly at the due edge. This confirms both the divider and the word length.

// File: rtl/spi_pkg.sv
package spi_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;
  localparam int WORD_MAX = 16;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_CFG   = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_TX    = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_RX    = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_CAUSE = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 5'h14;

  localparam int CFG_WIDE = 5;
  localparam int CFG_POL  = 11;
  localparam int CFG_PHA  = 12;

  // place the outgoing word so that its first bit sits at the top
  function automatic logic [WORD_MAX-1:0] tx_align(logic [DATA_W-1:0] w, logic wide);
    return wide ? w[WORD_MAX-1:0] : {w[7:0], 8'h00};
  endfunction

  // index of the final serial clock toggle of a word
  function automatic int unsigned final_toggle(logic wide);
    return wide ? 2 * WORD_MAX - 1 : WORD_MAX - 1;
  endfunction

  // received word as software sees it
  function automatic logic [DATA_W-1:0] rx_view(logic [WORD_MAX-1:0] r, logic wide);
    return wide ? {16'h0000, r} : {24'h000000, r[7:0]};
  endfunction
endpackage

// File: rtl/spi_clk_prescaler.sv
module spi_clk_prescaler #(
  parameter int DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!run || tick)   cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  // R11: with a divider above zero, two ticks are never adjacent
  p_tick_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0) |=> (!tick || div == '0));
endmodule

// File: rtl/spi_word_shifter.sv
module spi_word_shifter
  import spi_pkg::*;
#(
  parameter int EDGE_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [WORD_MAX-1:0] tx_word,
  input  logic                wide,
  input  logic                cpol,
  input  logic                cpha,
  input  logic                tick,
  input  logic                miso,
  output logic                busy,
  output logic                sclk_q,
  output logic                mosi,
  output logic [WORD_MAX-1:0] rx_word,
  output logic                done
);
  logic                busy_q, wide_q, cpol_q, cpha_q;
  logic [WORD_MAX-1:0] tx_q, rx_q;
  logic [EDGE_W-1:0]   edge_q;
  logic                leading, sample_now, shift_now;

  assign leading    = ~edge_q[0];
  assign sample_now = tick && (cpha_q ? !leading : leading);
  assign shift_now  = tick && (cpha_q ? (leading && edge_q != '0) : !leading);
  assign done       = tick && (edge_q == EDGE_W'(final_toggle(wide_q)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wide_q <= 1'b0;
      cpol_q <= 1'b0;
      cpha_q <= 1'b0;
      sclk_q <= 1'b0;
      tx_q   <= '0;
      rx_q   <= '0;
      edge_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      wide_q <= wide;
      cpol_q <= cpol;
      cpha_q <= cpha;
      sclk_q <= cpol;
      tx_q   <= tx_word;
      rx_q   <= '0;
      edge_q <= '0;
    end else if (tick) begin
      sclk_q <= ~sclk_q;
      edge_q <= edge_q + 1'b1;
      if (shift_now)  tx_q <= {tx_q[WORD_MAX-2:0], 1'b0};
      if (sample_now) rx_q <= {rx_q[WORD_MAX-2:0], miso};
      if (done)       busy_q <= 1'b0;
    end
  end

  assign busy    = busy_q;
  assign mosi    = busy_q & tx_q[WORD_MAX-1];
  assign rx_word = rx_q;

  // R4: an even number of toggles brings the clock back to its rest level
  p_sclk_home_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (sclk_q == cpol_q));
  // R5: between edges the data line holds still
  p_mosi_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && !$past(tick) && !$past(start)) |-> $stable(mosi));
  // R8: a word ends only through its final toggle
  p_busy_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(done));
endmodule

// File: rtl/spi_regs.sv
module spi_regs
  import spi_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_en,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic                busy,
  input  logic                done,
  input  logic [WORD_MAX-1:0] rx_word,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                cs_on,
  output logic [DATA_W-1:0]   cfg_q,
  output logic                tx_req
);
  logic wr, cause_q, clr_hit;

  assign wr      = bus_en && bus_we;
  assign tx_req  = wr && (bus_addr == OFS_TX);
  assign clr_hit = wr && (bus_addr == OFS_CAUSE) && (bus_wdata == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_on   <= 1'b0;
      cfg_q   <= '0;
      cause_q <= 1'b0;
    end else begin
      if (wr && bus_addr == OFS_CTRL) cs_on <= bus_wdata[0];
      if (wr && bus_addr == OFS_CFG)  cfg_q <= bus_wdata;
      if (done)         cause_q <= 1'b1;
      else if (clr_hit) cause_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (bus_addr)
      OFS_CTRL:  bus_rdata = {{(DATA_W-1){1'b0}}, cs_on};
      OFS_CFG:   bus_rdata = cfg_q;
      OFS_RX:    bus_rdata = rx_view(rx_word, cfg_q[CFG_WIDE]);
      OFS_CAUSE: bus_rdata = {{(DATA_W-1){1'b0}}, cause_q};
      OFS_STAT:  bus_rdata = {{(DATA_W-1){1'b0}}, busy};
      default:   bus_rdata = '0;
    endcase
  end

  // R8: completion is recorded on the next edge
  p_cause_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> cause_q);
  // R8: only a zero write removes the flag
  p_cause_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_q && !clr_hit) |=> cause_q);
endmodule

// File: rtl/spi_reg_master.sv
module spi_reg_master
  import spi_pkg::*;
#(
  parameter int DIV_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              spi_cs_n
);
  localparam int EDGE_W = $clog2(2 * WORD_MAX);

  logic                busy, done, tick, sclk_q, cs_on, tx_req, start;
  logic [DATA_W-1:0]   cfg_q;
  logic [WORD_MAX-1:0] rx_word;

  spi_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .busy(busy), .done(done),
    .rx_word(rx_word), .bus_rdata(bus_rdata), .cs_on(cs_on),
    .cfg_q(cfg_q), .tx_req(tx_req)
  );

  // R9: a request during a word is dropped here
  assign start = tx_req && !busy;

  spi_clk_prescaler #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy),
    .div(cfg_q[DIV_W-1:0]), .tick(tick)
  );

  spi_word_shifter #(.EDGE_W(EDGE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(start),
    .tx_word(tx_align(bus_wdata, cfg_q[CFG_WIDE])),
    .wide(cfg_q[CFG_WIDE]), .cpol(cfg_q[CFG_POL]), .cpha(cfg_q[CFG_PHA]),
    .tick(tick), .miso(spi_miso), .busy(busy), .sclk_q(sclk_q),
    .mosi(spi_mosi), .rx_word(rx_word), .done(done)
  );

  assign spi_sclk = busy ? sclk_q : cfg_q[CFG_POL];
  assign spi_cs_n = ~cs_on;

  // R2: chip select pin follows the written control bit
  p_cs_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && bus_addr == OFS_CTRL) |=> (spi_cs_n == !$past(bus_wdata[0])));
endmodule

// File: tb/tb_spi_reg_master.sv
module tb_spi_reg_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        spi_sclk, spi_mosi, spi_cs_n;
  logic        spi_miso = 1'b0;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  spi_reg_master dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_cs_n(spi_cs_n)
  );

  // ---------------- behavioural reference model ----------------
  bit          m_busy, m_cs, m_cause, m_cpol, m_cpha;
  int          m_t, m_n, m_d;
  logic [31:0] m_cfg, m_word, m_slave, m_din;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_cs = 0; m_cause = 0; m_cfg = '0; m_t = 0; m_n = 8; m_d = 1;
      m_din = '0;
    end else begin
      bit was_busy, fin;
      was_busy = m_busy; fin = 0;
      if (m_busy) begin
        m_t++;
        if (m_t == 2 * m_n * m_d) begin m_busy = 0; fin = 1; end
      end
      if (bus_en && bus_we) begin
        case (bus_addr)
          5'h00: m_cs = bus_wdata[0];
          5'h04: m_cfg = bus_wdata;
          5'h08: if (!was_busy) begin
                   m_busy = 1; m_t = 0;
                   m_n = m_cfg[5] ? 16 : 8;
                   m_d = int'(m_cfg[4:0]) + 1;
                   m_cpol = m_cfg[11]; m_cpha = m_cfg[12];
                   m_word = bus_wdata & ((32'd1 << m_n) - 1);
                 end
          5'h10: if (bus_wdata == 0) m_cause = 0;
          default: ;
        endcase
      end
      if (fin) begin
        m_cause = 1;
        m_din = m_slave & ((32'd1 << m_n) - 1);
      end
    end
  end

  function automatic int bit_slot(int e, bit pha);
    if (!pha) return e / 2;
    return (e == 0) ? 0 : (e + 1) / 2 - 1;
  endfunction

  // compare pins every cycle, and present the slave's bit
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int e, j;
      logic x_sclk, x_mosi;
      e = m_busy ? m_t / m_d : 0;
      j = bit_slot(e, m_cpha);
      x_sclk = m_busy ? (m_cpol ^ e[0]) : m_cfg[11];
      x_mosi = m_busy ? m_word[m_n - 1 - j] : 1'b0;
      spi_miso = m_busy ? m_slave[m_n - 1 - j] : 1'b0;
      checks++;
      if (spi_sclk !== x_sclk) begin
        failures++; $display("FAIL R4/R11 sclk t=%0t got %b exp %b", $time, spi_sclk, x_sclk);
      end
      if (spi_mosi !== x_mosi) begin
        failures++; $display("FAIL R5/R6 mosi t=%0t got %b exp %b", $time, spi_mosi, x_mosi);
      end
      if (spi_cs_n !== !m_cs) begin
        failures++; $display("FAIL R2 cs_n t=%0t got %b exp %b", $time, spi_cs_n, !m_cs);
      end
    end
  end

  // ---------------- bus tasks ----------------
  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    bus_en = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 0;
  endtask

  task automatic expect_reg(input logic [4:0] a, input logic [31:0] exp, input string req);
    logic [31:0] got;
    bus_read(a, got);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s reg 0x%02h got 0x%08h exp 0x%08h", req, a, got, exp);
    end
  endtask

  task automatic wait_idle();
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  // one word; timed=1 checks the completion edge, poke=1 writes during the word
  task automatic run_word(input logic [31:0] cfg, input logic [31:0] tx,
                          input logic [31:0] slave, input bit timed, input bit poke);
    int n, d, f0;
    n = cfg[5] ? 16 : 8;
    d = int'(cfg[4:0]) + 1;
    bus_write(5'h04, cfg);
    bus_write(5'h10, 32'h0);
    m_slave = slave;
    bus_write(5'h08, tx);
    if (timed) begin
      repeat (2 * n * d - 1) @(negedge clk);
      expect_reg(5'h14, 32'h1, "R10 busy before due edge");
      expect_reg(5'h10, 32'h0, "R8 cause before due edge");
      @(negedge clk);
      expect_reg(5'h14, 32'h0, "R10 idle at due edge");
      expect_reg(5'h10, 32'h1, "R8 cause at due edge R11");
    end else begin
      f0 = failures;
      if (poke) begin
        repeat (3) @(negedge clk);
        bus_write(5'h08, ~tx);
      end
      wait_idle();
      checks++;
      if (poke && failures != f0) begin
        failures++; $display("FAIL R9 word disturbed got %0d pin errors exp 0", failures - f0);
      end
      expect_reg(5'h10, 32'h1, "R8 cause set");
    end
    expect_reg(5'h0C, slave & ((32'd1 << n) - 1), n == 16 ? "R7 data-in" : "R12 data-in");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    expect_reg(5'h04, 32'h0, "R1 cfg");
    expect_reg(5'h10, 32'h0, "R1 cause");
    expect_reg(5'h14, 32'h0, "R1 status");
    checks++;
    if (spi_cs_n !== 1'b1 || spi_sclk !== 1'b0 || spi_mosi !== 1'b0) begin
      failures++; $display("FAIL R1 pins got %b%b%b exp 100", spi_cs_n, spi_sclk, spi_mosi);
    end
    // R3
    bus_write(5'h04, 32'hA5A5_5A5A);
    expect_reg(5'h04, 32'hA5A5_5A5A, "R3 readback");
    checks++;
    if (spi_sclk !== 1'b1) begin
      failures++; $display("FAIL R4 idle sclk got %b exp 1", spi_sclk);
    end
    // R2
    bus_write(5'h00, 32'h1);
    checks++;
    if (spi_cs_n !== 1'b0) begin failures++; $display("FAIL R2 cs_n got %b exp 0", spi_cs_n); end
    expect_reg(5'h00, 32'h1, "R2 ctrl");
    // words: mode 0 8-bit, mode 3 16-bit, mode 1 8-bit with poke, mode 2 16-bit
    run_word(32'h0000_0001, 32'h0000_00A5, 32'h0000_003C, 1, 0);
    run_word(32'h0000_1820, 32'h1234_BEEF, 32'hFFFF_C0DE, 0, 0);
    run_word(32'h0000_1003, 32'h0000_01FF, 32'h0000_0181, 0, 1);
    run_word(32'h0000_0822, 32'h0000_4D2B, 32'h0000_9A17, 1, 0);
    // R8: nonzero write keeps the flag, zero clears it
    bus_write(5'h10, 32'h5);
    expect_reg(5'h10, 32'h1, "R8 nonzero write");
    bus_write(5'h10, 32'h0);
    expect_reg(5'h10, 32'h0, "R8 clear");
    bus_write(5'h00, 32'h0);
    checks++;
    if (spi_cs_n !== 1'b1) begin failures++; $display("FAIL R2 cs_n got %b exp 1", spi_cs_n); end
    repeat (2) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog expired got hang exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule